// File: doc/BRIEF.md
# Call-Gate Privilege Transition Sequencer

This block carries out a far call from one privilege ring to an equal or more trusted ring through a 64-bit gate descriptor, and the matching far return, for a 16-bit segmented machine. A request latches the gate and the caller's CS, IP, SS and SP. The block checks the gate against the current privilege. When the ring changes, it reads the inner stack pointer pair from a per-ring stack table in memory, switches to that stack, and saves the caller's stack pointer pair there. It then copies a counted number of parameter words from the old stack, saves the return address, and presents the new CS:IP and SS:SP. A return request pops the saved frame again and may optionally skip parameter bytes. The return may go back to the same ring or out to a less trusted ring, and it faults when it would go inward.

The memory port is one word wide and addressed as segment plus byte offset. A read returns its data on the cycle after the request. A write completes in the cycle of its request. Any failed check produces a one-cycle fault pulse with a cause code. In that case no stack word is written and the output registers keep their values. A successful operation produces a one-cycle done pulse, and the new register values appear in the same cycle.

Top module: `cg_call_gate_seq`

## Requirements
- R1: After reset, done, fault and busy are low, fault_cause is 0, and new_cs, new_ip, new_ss and new_sp are all zero.
- R2: The gate type is bits 43..40 of the gate. Only 4'h4 and 4'hC are accepted, and any other type faults with cause 1. When several checks fail, the cause reported is the first failing one in this order: type (1), present (2), descriptor privilege (3), target privilege (4).
- R3: A gate whose present bit (bit 47) is 0 faults with cause 2.
- R4: CPL is cur_cs[1:0] and the gate privilege is bits 46..45 of the gate. A call faults with cause 3 when CPL is numerically greater than the gate privilege. It faults with cause 4 when the target ring, taken from bits 17..16 of the gate (the low bits of the code selector), is numerically greater than CPL.
- R5: A fault is a single-cycle pulse on fault, with the cause on fault_cause. During a faulting operation no memory write occurs and new_cs, new_ip, new_ss and new_sp keep their values. done is asserted only on success and never together with fault.
- R6: On a call to a more trusted ring r, the new SP is read from segment tss_seg at byte offset 2+4r, and the new SS is read from offset 4+4r.
- R7: A ring-changing call with k parameters (k taken from bits 36..32 of the gate) writes the new stack from new SP downward in steps of 2. Old SS goes at new SP-2 and old SP at new SP-4. The k parameters follow, then old CS, then old IP. The resulting SP is the table SP minus 8+2k.
- R8: The parameter word at old SP+2j is placed at table SP-4-2k+2j, so the parameters keep their order.
- R9: A call whose target ring equals CPL reads no memory. It writes CS at SP-2 and IP at SP-4 on the current stack, and it finishes with SS unchanged and SP reduced by 4.
- R10: On a successful call, new_cs is gate bits 31..16 and new_ip is gate bits 15..0. Gate bits 63..48 have no effect.
- R11: A return pops IP from SS:SP and CS from SS:SP+2. When the popped CS selects a less trusted ring, it then reads the outer SP at SP+4+n and the outer SS at SP+6+n, where n is ret_imm, and it loads all four registers from these words.
- R12: A return whose popped CS selects the current ring leaves SS unchanged and sets SP to SP+4+n.
- R13: A return whose popped CS selects a more trusted ring than CPL faults with cause 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Start a gate call (taken when idle) |
| ret_req | input | 1 | Start a far return (taken when idle, call has priority) |
| gate | input | 64 | Gate descriptor |
| ret_imm | input | 16 | Parameter bytes skipped by the return |
| cur_cs | input | 16 | Caller code selector |
| cur_ip | input | 16 | Caller instruction pointer |
| cur_ss | input | 16 | Caller stack selector |
| cur_sp | input | 16 | Caller stack pointer |
| tss_seg | input | 16 | Segment holding the per-ring stack table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_seg | output | 16 | Access segment |
| mem_off | output | 16 | Access byte offset |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 3 | Cause code of the fault |
| new_cs | output | 16 | Resulting CS |
| new_ip | output | 16 | Resulting IP |
| new_ss | output | 16 | Resulting SS |
| new_sp | output | 16 | Resulting SP |

## Verification
The hardest case to reach is the parameter copy during a ring-changing call. In that case reads from the old stack and writes to the new one alternate, and a slip in order or offset shows only in memory contents. The bench preloads distinct words on the old stack and a distinct stack table entry for each ring, then inspects every word of the new frame. It then feeds that same frame back through a return with n equal to the parameter bytes, so the round trip has to restore the caller's registers exactly. Faults are driven after successful calls, so that unchanged outputs are distinguishable from zeros, and a memory write counter shows that no fault writes the stack.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CNT_W  = 5;
  localparam int unsigned RING_W = 2;
  localparam logic [3:0]  GT_CALL16 = 4'h4;
  localparam logic [3:0]  GT_CALL32 = 4'hC;

  typedef logic [WORD_W-1:0] word_t;
  localparam word_t STEP = word_t'(2);

  typedef enum logic [2:0] {
    C_NONE   = 3'd0,
    C_TYPE   = 3'd1,
    C_ABSENT = 3'd2,
    C_DPL    = 3'd3,
    C_TARGET = 3'd4,
    C_INWARD = 3'd5
  } cause_t;

  function automatic word_t push_ptr(word_t sp);
    return sp - STEP;
  endfunction

  function automatic word_t tbl_sp_slot(logic [RING_W-1:0] ring);
    return STEP + (word_t'(ring) << 2);
  endfunction

  function automatic word_t tbl_ss_slot(logic [RING_W-1:0] ring);
    return tbl_sp_slot(ring) + STEP;
  endfunction

  // deepest remaining parameter: old SP + 2*(n-1)
  function automatic word_t param_slot(word_t sp, logic [CNT_W-1:0] n);
    return sp + ((word_t'(n) - word_t'(1)) << 1);
  endfunction

  function automatic word_t frame_slot(word_t sp, word_t skip, word_t words);
    return sp + skip + (words << 1);
  endfunction
endpackage

// File: rtl/cg_gate_check.sv
module cg_gate_check
  import cg_pkg::*;
(
  input  logic [63:0]       gate,
  input  logic [RING_W-1:0] cpl,
  output cause_t            cause,
  output logic [RING_W-1:0] tgt_rpl,
  output logic              same_ring
);
  logic [3:0]        g_type;
  logic [RING_W-1:0] g_dpl;
  logic              g_present;
  logic              unused_gate_bits;

  assign g_type    = gate[43:40];
  assign g_dpl     = gate[46:45];
  assign g_present = gate[47];
  assign tgt_rpl   = gate[17:16];
  assign same_ring = (tgt_rpl == cpl);
  assign unused_gate_bits = ^{gate[63:48], gate[44], gate[39:37], gate[31:18], gate[15:0]};

  always_comb begin
    if (g_type != GT_CALL16 && g_type != GT_CALL32) cause = C_TYPE;
    else if (!g_present)                            cause = C_ABSENT;
    else if (cpl > g_dpl)                           cause = C_DPL;
    else if (tgt_rpl > cpl)                         cause = C_TARGET;
    else                                            cause = C_NONE;
  end
endmodule

// File: rtl/cg_ret_check.sv
module cg_ret_check
  import cg_pkg::*;
(
  input  logic [RING_W-1:0] popped_rpl,
  input  logic [RING_W-1:0] cpl,
  output logic              inward,
  output logic              same_ring
);
  assign inward    = (popped_rpl < cpl);
  assign same_ring = (popped_rpl == cpl);
endmodule

// File: rtl/cg_call_gate_seq.sv
module cg_call_gate_seq
  import cg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        call_req,
  input  logic        ret_req,
  input  logic [63:0] gate,
  input  logic [15:0] ret_imm,
  input  logic [15:0] cur_cs,
  input  logic [15:0] cur_ip,
  input  logic [15:0] cur_ss,
  input  logic [15:0] cur_sp,
  input  logic [15:0] tss_seg,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_seg,
  output logic [15:0] mem_off,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [2:0]  fault_cause,
  output logic [15:0] new_cs,
  output logic [15:0] new_ip,
  output logic [15:0] new_ss,
  output logic [15:0] new_sp
);
  typedef enum logic [4:0] {
    S_IDLE, S_CHK, S_RD_TSP, S_RD_TSS, S_CAP_TSS, S_PSH_SS, S_PSH_SP,
    S_RD_PAR, S_PSH_PAR, S_PSH_CS, S_PSH_IP,
    S_R_IP, S_R_CS, S_R_CHK, S_R_SP, S_R_SS, S_R_FIN
  } st_t;

  st_t              st;
  logic [63:0]      gate_q;
  word_t            cs_q, ip_q, ss_q, sp_q, imm_q, nss, nsp;
  logic [CNT_W-1:0] cnt_q;
  cause_t           cause_q, gc_cause;
  logic [RING_W-1:0] gc_tgt;
  logic             gc_same, rc_inward, rc_same;
  logic             ev_push;

  cg_gate_check u_gchk (
    .gate(gate_q), .cpl(cs_q[RING_W-1:0]),
    .cause(gc_cause), .tgt_rpl(gc_tgt), .same_ring(gc_same)
  );

  cg_ret_check u_rchk (
    .popped_rpl(mem_rdata[RING_W-1:0]), .cpl(cs_q[RING_W-1:0]),
    .inward(rc_inward), .same_ring(rc_same)
  );

  assign busy        = (st != S_IDLE);
  assign fault_cause = cause_q;
  assign ev_push     = mem_req & mem_we;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_seg   = ss_q;
    mem_off   = sp_q;
    mem_wdata = ss_q;
    unique case (st)
      S_RD_TSP:  begin mem_req = 1'b1; mem_seg = tss_seg; mem_off = tbl_sp_slot(gc_tgt); end
      S_RD_TSS:  begin mem_req = 1'b1; mem_seg = tss_seg; mem_off = tbl_ss_slot(gc_tgt); end
      S_PSH_SS:  begin mem_req = 1'b1; mem_we = 1'b1; mem_seg = nss; mem_off = push_ptr(nsp); mem_wdata = ss_q; end
      S_PSH_SP:  begin mem_req = 1'b1; mem_we = 1'b1; mem_seg = nss; mem_off = push_ptr(nsp); mem_wdata = sp_q; end
      S_RD_PAR:  begin mem_req = 1'b1; mem_off = param_slot(sp_q, cnt_q); end
      S_PSH_PAR: begin mem_req = 1'b1; mem_we = 1'b1; mem_seg = nss; mem_off = push_ptr(nsp); mem_wdata = mem_rdata; end
      S_PSH_CS:  begin mem_req = 1'b1; mem_we = 1'b1; mem_seg = nss; mem_off = push_ptr(nsp); mem_wdata = cs_q; end
      S_PSH_IP:  begin mem_req = 1'b1; mem_we = 1'b1; mem_seg = nss; mem_off = push_ptr(nsp); mem_wdata = ip_q; end
      S_R_IP:    begin mem_req = 1'b1; mem_off = frame_slot(sp_q, '0, word_t'(0)); end
      S_R_CS:    begin mem_req = 1'b1; mem_off = frame_slot(sp_q, '0, word_t'(1)); end
      S_R_SP:    begin mem_req = 1'b1; mem_off = frame_slot(sp_q, imm_q, word_t'(2)); end
      S_R_SS:    begin mem_req = 1'b1; mem_off = frame_slot(sp_q, imm_q, word_t'(3)); end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; gate_q <= '0; cs_q <= '0; ip_q <= '0; ss_q <= '0; sp_q <= '0;
      imm_q <= '0; nss <= '0; nsp <= '0; cnt_q <= '0; cause_q <= C_NONE;
      done <= 1'b0; fault <= 1'b0;
      new_cs <= '0; new_ip <= '0; new_ss <= '0; new_sp <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      unique case (st)
        S_IDLE: begin
          cause_q <= C_NONE;
          if (call_req) begin
            gate_q <= gate; cs_q <= cur_cs; ip_q <= cur_ip; ss_q <= cur_ss; sp_q <= cur_sp;
            st <= S_CHK;
          end else if (ret_req) begin
            cs_q <= cur_cs; ss_q <= cur_ss; sp_q <= cur_sp; imm_q <= ret_imm;
            st <= S_R_IP;
          end
        end
        S_CHK: begin
          cnt_q <= gate_q[36:32];
          if (gc_cause != C_NONE) begin
            fault <= 1'b1; cause_q <= gc_cause; st <= S_IDLE;
          end else if (gc_same) begin
            nss <= ss_q; nsp <= sp_q; st <= S_PSH_CS;
          end else begin
            st <= S_RD_TSP;
          end
        end
        S_RD_TSP:  st <= S_RD_TSS;
        S_RD_TSS:  begin nsp <= mem_rdata; st <= S_CAP_TSS; end
        S_CAP_TSS: begin nss <= mem_rdata; st <= S_PSH_SS; end
        S_PSH_SS:  begin nsp <= push_ptr(nsp); st <= S_PSH_SP; end
        S_PSH_SP: begin
          nsp <= push_ptr(nsp);
          st  <= (cnt_q != '0) ? S_RD_PAR : S_PSH_CS;
        end
        S_RD_PAR:  st <= S_PSH_PAR;
        S_PSH_PAR: begin
          nsp   <= push_ptr(nsp);
          cnt_q <= cnt_q - CNT_W'(1);
          st    <= (cnt_q == CNT_W'(1)) ? S_PSH_CS : S_RD_PAR;
        end
        S_PSH_CS:  begin nsp <= push_ptr(nsp); st <= S_PSH_IP; end
        S_PSH_IP: begin
          done <= 1'b1;
          new_cs <= gate_q[31:16]; new_ip <= gate_q[15:0];
          new_ss <= nss;           new_sp <= push_ptr(nsp);
          st <= S_IDLE;
        end
        S_R_IP: st <= S_R_CS;
        S_R_CS: begin ip_q <= mem_rdata; st <= S_R_CHK; end
        S_R_CHK: begin
          if (rc_inward) begin
            fault <= 1'b1; cause_q <= C_INWARD; st <= S_IDLE;
          end else if (rc_same) begin
            done <= 1'b1;
            new_cs <= mem_rdata; new_ip <= ip_q; new_ss <= ss_q;
            new_sp <= frame_slot(sp_q, imm_q, word_t'(2));
            st <= S_IDLE;
          end else begin
            cs_q <= mem_rdata; st <= S_R_SP;
          end
        end
        S_R_SP: st <= S_R_SS;
        S_R_SS: begin nsp <= mem_rdata; st <= S_R_FIN; end
        S_R_FIN: begin
          done <= 1'b1;
          new_cs <= cs_q; new_ip <= ip_q; new_ss <= mem_rdata; new_sp <= nsp;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cg_call_gate_chk.sv
module cg_call_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [2:0]  fault_cause,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_off,
  input logic        ev_push,
  input logic [15:0] new_cs,
  input logic [15:0] new_ip,
  input logic [15:0] new_ss,
  input logic [15:0] new_sp
);
  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault));

  assert_fault_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n) fault |=> !fault);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(new_cs) && $stable(new_ip) && $stable(new_ss) && $stable(new_sp)));

  assert_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_cause >= 3'd1 && fault_cause <= 3'd5));

  assert_write_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && busy));

  assert_push_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && $past(ev_push)) |-> (mem_off == $past(mem_off) - 16'd2));
endmodule

bind cg_call_gate_seq cg_call_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .fault_cause(fault_cause), .mem_req(mem_req), .mem_we(mem_we),
  .mem_off(mem_off), .ev_push(ev_push),
  .new_cs(new_cs), .new_ip(new_ip), .new_ss(new_ss), .new_sp(new_sp)
);

// File: tb/cg_call_gate_seq_tb.sv
module cg_call_gate_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_req = 1'b0, ret_req = 1'b0;
  logic [63:0] gate = '0;
  logic [15:0] ret_imm = '0, cur_cs = '0, cur_ip = '0, cur_ss = '0, cur_sp = '0;
  logic [15:0] tss_seg = 16'h0040;
  logic mem_req, mem_we, busy, done, fault;
  logic [15:0] mem_seg, mem_off, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [2:0] fault_cause;
  logic [15:0] new_cs, new_ip, new_ss, new_sp;

  always #4 clk = ~clk;

  cg_call_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req), .gate(gate),
    .ret_imm(ret_imm), .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp),
    .tss_seg(tss_seg), .mem_req(mem_req), .mem_we(mem_we), .mem_seg(mem_seg),
    .mem_off(mem_off), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .fault(fault), .fault_cause(fault_cause),
    .new_cs(new_cs), .new_ip(new_ip), .new_ss(new_ss), .new_sp(new_sp)
  );

  // word memory keyed by {segment, offset}
  logic [15:0] mem [logic [31:0]];
  int wr_cnt = 0, rd_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit summary_done = 0;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[{mem_seg, mem_off}] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata <= mem.exists({mem_seg, mem_off}) ? mem[{mem_seg, mem_off}] : 16'hDEAD;
        rd_cnt++;
      end
    end
  end

  function automatic logic [15:0] peek(logic [15:0] s, logic [15:0] o);
    return mem.exists({s, o}) ? mem[{s, o}] : 16'hDEAD;
  endfunction

  task automatic poke(logic [15:0] s, logic [15:0] o, logic [15:0] v);
    mem[{s, o}] = v;
  endtask

  // scoreboard
  bit          q_flt [$];
  logic [2:0]  q_cause [$];
  logic [63:0] q_regs [$];
  string       q_tag [$];
  logic [15:0] last_cs = '0, last_ip = '0, last_ss = '0, last_sp = '0;

  task automatic expect_ok(logic [15:0] cs, ip, ss, sp, string tag);
    q_flt.push_back(1'b0); q_cause.push_back(3'd0);
    q_regs.push_back({cs, ip, ss, sp}); q_tag.push_back(tag);
    last_cs = cs; last_ip = ip; last_ss = ss; last_sp = sp;
  endtask

  task automatic expect_fault(logic [2:0] cause, string tag);
    q_flt.push_back(1'b1); q_cause.push_back(cause);
    q_regs.push_back({last_cs, last_ip, last_ss, last_sp}); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && (done || fault)) begin
      n_chk++;
      if (q_flt.size() == 0) begin
        n_bad++;
        $display("FAIL R5: unexpected result done=%0b fault=%0b expected none", done, fault);
      end else begin
        bit f; logic [2:0] c; logic [63:0] r; string t;
        f = q_flt.pop_front(); c = q_cause.pop_front(); r = q_regs.pop_front(); t = q_tag.pop_front();
        if (fault !== f || done !== !f || (f && fault_cause !== c) ||
            {new_cs, new_ip, new_ss, new_sp} !== r) begin
          n_bad++;
          $display("FAIL %s: got flt=%0b cause=%0d regs=%h expected flt=%0b cause=%0d regs=%h",
                   t, fault, fault_cause, {new_cs, new_ip, new_ss, new_sp}, f, c, r);
        end
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_mem(logic [15:0] s, o, v, string tag);
    check(peek(s, o) === v, tag, {s, peek(s, o)}, {o, v});
  endtask

  function automatic logic [63:0] mk_gate(logic [15:0] off, sel, logic [4:0] cnt,
                                          logic [3:0] typ, logic [1:0] dpl, logic p);
    return {16'hBEEF, p, dpl, 1'b0, typ, 3'b000, cnt, sel, off};
  endfunction

  task automatic wait_result();
    do @(negedge clk); while (!(done || fault));
  endtask

  task automatic do_call(logic [63:0] g, logic [15:0] cs, ip, ss, sp);
    @(negedge clk);
    gate = g; cur_cs = cs; cur_ip = ip; cur_ss = ss; cur_sp = sp; call_req = 1'b1;
    @(negedge clk);
    call_req = 1'b0;
    wait_result();
  endtask

  task automatic do_ret(logic [15:0] cs, ss, sp, imm);
    @(negedge clk);
    cur_cs = cs; cur_ss = ss; cur_sp = sp; ret_imm = imm; ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    wait_result();
  endtask

  task automatic finish_up();
    if (!summary_done) begin
      summary_done = 1;
      if (q_flt.size() != 0) begin
        n_chk++; n_bad++;
        $display("FAIL R5: %0d expected results never produced, expected 0", q_flt.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    int wr0, rd0;
    // stack table: ring0, ring1, ring2 SP/SS pairs
    poke(16'h0040, 16'h0000, 16'h9999);
    poke(16'h0040, 16'h0002, 16'h0800); poke(16'h0040, 16'h0004, 16'h0010);
    poke(16'h0040, 16'h0006, 16'h0600); poke(16'h0040, 16'h0008, 16'h0019);
    poke(16'h0040, 16'h000A, 16'h0400); poke(16'h0040, 16'h000C, 16'h001A);
    // old ring-3 stack parameters
    poke(16'h0033, 16'h0F00, 16'hA000); poke(16'h0033, 16'h0F02, 16'hA001);
    poke(16'h0033, 16'h0F04, 16'hA002);

    repeat (3) @(negedge clk);
    // R1: reset state
    check({done, fault, busy, fault_cause} === 6'b0, "R1 flags", {26'b0, done, fault, busy, fault_cause}, 32'h0);
    check({new_cs, new_ip, new_ss, new_sp} === 64'h0, "R1 regs", {new_cs, new_ip}, 32'h0);
    rst_n = 1'b1;

    // ring 3 -> ring 0, three parameters (R6 R7 R8 R10)
    expect_ok(16'h0008, 16'h4000, 16'h0010, 16'h07F2, "R6 R7 R10 call 3->0");
    do_call(mk_gate(16'h4000, 16'h0008, 5'd3, 4'h4, 2'd3, 1'b1), 16'h002B, 16'h1234, 16'h0033, 16'h0F00);
    chk_mem(16'h0010, 16'h07FE, 16'h0033, "R7 old SS");
    chk_mem(16'h0010, 16'h07FC, 16'h0F00, "R7 old SP");
    chk_mem(16'h0010, 16'h07F6, 16'hA000, "R8 param0");
    chk_mem(16'h0010, 16'h07F8, 16'hA001, "R8 param1");
    chk_mem(16'h0010, 16'h07FA, 16'hA002, "R8 param2");
    chk_mem(16'h0010, 16'h07F4, 16'h002B, "R7 old CS");
    chk_mem(16'h0010, 16'h07F2, 16'h1234, "R7 old IP");

    // round-trip return with n = 6 (R11)
    expect_ok(16'h002B, 16'h1234, 16'h0033, 16'h0F00, "R11 return 0->3");
    do_ret(16'h0008, 16'h0010, 16'h07F2, 16'd6);

    // ring 2 -> ring 1, 32-bit gate type, no parameters (R6 R7)
    expect_ok(16'h0011, 16'h5000, 16'h0019, 16'h05F8, "R6 call 2->1");
    do_call(mk_gate(16'h5000, 16'h0011, 5'd0, 4'hC, 2'd2, 1'b1), 16'h001A, 16'h0100, 16'h0022, 16'h0E00);
    chk_mem(16'h0019, 16'h05FE, 16'h0022, "R7 r1 old SS");
    chk_mem(16'h0019, 16'h05FC, 16'h0E00, "R7 r1 old SP");
    chk_mem(16'h0019, 16'h05FA, 16'h001A, "R7 r1 old CS");
    chk_mem(16'h0019, 16'h05F8, 16'h0100, "R7 r1 old IP");

    // ring 3 -> ring 2, one parameter (R6 R8)
    expect_ok(16'h0052, 16'h7000, 16'h001A, 16'h03F6, "R6 call 3->2");
    do_call(mk_gate(16'h7000, 16'h0052, 5'd1, 4'h4, 2'd3, 1'b1), 16'h002B, 16'h0ABC, 16'h0033, 16'h0F00);
    chk_mem(16'h001A, 16'h03FA, 16'hA000, "R8 r2 param0");
    chk_mem(16'h001A, 16'h03F6, 16'h0ABC, "R7 r2 old IP");

    // same ring call (R9)
    rd0 = rd_cnt;
    expect_ok(16'h0031, 16'h6000, 16'h0019, 16'h04FC, "R9 same-ring call");
    do_call(mk_gate(16'h6000, 16'h0031, 5'd4, 4'h4, 2'd1, 1'b1), 16'h0011, 16'h0200, 16'h0019, 16'h0500);
    chk_mem(16'h0019, 16'h04FE, 16'h0011, "R9 CS push");
    chk_mem(16'h0019, 16'h04FC, 16'h0200, "R9 IP push");
    check(rd_cnt == rd0, "R9 no reads", rd_cnt, rd0);

    // faults (R2 R3 R4 R5)
    wr0 = wr_cnt;
    expect_fault(3'd1, "R2 bad type");
    do_call(mk_gate(16'h4000, 16'h0008, 5'd0, 4'h5, 2'd3, 1'b1), 16'h002B, 16'h1, 16'h0033, 16'h0F00);
    expect_fault(3'd2, "R3 not present");
    do_call(mk_gate(16'h4000, 16'h0008, 5'd0, 4'h4, 2'd3, 1'b0), 16'h002B, 16'h1, 16'h0033, 16'h0F00);
    expect_fault(3'd3, "R4 dpl");
    do_call(mk_gate(16'h4000, 16'h0008, 5'd0, 4'h4, 2'd2, 1'b1), 16'h002B, 16'h1, 16'h0033, 16'h0F00);
    expect_fault(3'd4, "R4 target outward");
    do_call(mk_gate(16'h4000, 16'h0052, 5'd0, 4'h4, 2'd3, 1'b1), 16'h0011, 16'h1, 16'h0019, 16'h0500);
    expect_fault(3'd1, "R2 priority");
    do_call(mk_gate(16'h4000, 16'h0052, 5'd0, 4'h0, 2'd0, 1'b0), 16'h002B, 16'h1, 16'h0033, 16'h0F00);
    check(wr_cnt == wr0, "R5 no writes on fault", wr_cnt, wr0);
    @(negedge clk);
    check(!fault && !done, "R5 single pulse", {fault, done}, 32'h0);

    // same-ring return, n = 4 (R12)
    poke(16'h0019, 16'h0300, 16'h7777); poke(16'h0019, 16'h0302, 16'h0031);
    expect_ok(16'h0031, 16'h7777, 16'h0019, 16'h0308, "R12 same-ring return");
    do_ret(16'h0011, 16'h0019, 16'h0300, 16'd4);

    // inward return fault (R13)
    poke(16'h0033, 16'h0A00, 16'h1111); poke(16'h0033, 16'h0A02, 16'h0008);
    expect_fault(3'd5, "R13 inward return");
    do_ret(16'h002B, 16'h0033, 16'h0A00, 16'd0);

    // outward return ring1 -> ring2, n = 0 (R11)
    poke(16'h0019, 16'h0200, 16'h2222); poke(16'h0019, 16'h0202, 16'h001A);
    poke(16'h0019, 16'h0204, 16'h0C00); poke(16'h0019, 16'h0206, 16'h0022);
    expect_ok(16'h001A, 16'h2222, 16'h0022, 16'h0C00, "R11 return 1->2");
    do_ret(16'h0011, 16'h0019, 16'h0200, 16'd0);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule